// File: doc/BRIEF.md
# Hierarchical Performance Counter Unit

The unit counts events for several counter boxes and reports overflows at two levels. Each box has four programmable event counters and one fixed counter that counts clock cycles. Every counter is 48 bits wide. Each programmable counter has its own select register. That register picks one line of the box's event vector and enables the counter.

A box has three registers that act on its counters together:

- a control register, which enables counting and the overflow interrupt;
- a sticky status register, with one overflow flag per counter;
- a clear register, where a bit written as 1 clears the matching flag.

A global controller sits above the boxes. It has a master count enable, a global interrupt enable, and its own status register with one sticky flag per box. The global flags are cleared through a separate global clear register.

Software reaches every register through a single-cycle write port, and reads through a combinational port. Both ports share one address bus. The unit raises one interrupt line while any box that has overflowed has its interrupt enabled at both levels.

Top module: `pcu_top`

## Requirements
- R1: After reset, every counter, select register, control register and status register reads 0, and `irq` is low.
- R2: The address bus is split into two fields. `reg_addr[7:4]` selects a box, from 0 to N_BOX-1, or the global controller, which is unit 15. `reg_addr[3:0]` selects a register within that unit.
  - Box registers: 0 to 3 are the programmable counters, 4 is the fixed counter, 5 to 8 are the select registers, 9 is control, 10 is status, and 11 is overflow clear.
  - Global registers: 0 is control, 1 is status, and 2 is overflow clear.
  - Written values read back on the next cycle. Unmapped addresses and the clear registers read 0, and a write to an unmapped address changes nothing.
- R3: A programmable counter increments by exactly one at a clock edge when all four of these are true at that edge:
  - global control bit 0 is set;
  - its box control bit 0 is set;
  - its select register bit 4 is set;
  - the event line `ev_in[box*8 + sel]` is high, where `sel` is select register bits [2:0].
- R4: A programmable counter does not change if any one of the enables in R3 is clear or its event line is low.
- R5: The fixed counter of a box increments on every clock edge at which global control bit 0 and box control bit 0 are both set. It ignores all event lines.
- R6: When a counter steps from 2^48-1, it reads 0, and its box status bit is set at the same edge. Programmable counter i uses bit i and the fixed counter uses bit 4.
- R7: Box status bits stay set until a 1 is written to the matching bit of the box clear register. A 0 written to that register has no effect. Writes to the status register are ignored. A new overflow at the same edge as a clear leaves the bit set.
- R8: Global status bit b is set at the same edge at which box b's status is nonzero. It stays set until a 1 is written to global clear bit b, and that clear takes effect only while box b's status is zero.
- R9: `irq` is high exactly when global control bit 1 is set and there is some box b whose global status bit is set and whose box control bit 1 is set.
- R10: A write to a counter at the same edge as an increment loads the written value, and that step sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address: unit in [7:4], register in [3:0] |
| reg_wdata | input | 48 | Register write data |
| reg_rdata | output | 48 | Combinational read data for `reg_addr` |
| ev_in | input | N_BOX*8 | Event lines, 8 per box, with box b on bits [b*8+7:b*8] |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest situations to reach are a 48-bit wrap and a collision between an overflow and a clear of the same status bit. Counting up to a wrap from reset is not practical. The stimulus therefore preloads counters a few steps below all ones and keeps their event lines high. It then times the box-clear write so that it lands on the exact edge of the wrap. It also writes a counter that is already at all ones on the edge where the counter would wrap. The global clear is tried both before and after the matching box clear, to show that the global flag survives while its box still reports an overflow.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int UNIT_W      = 4;
  localparam int IDX_W       = 4;
  localparam logic [UNIT_W-1:0] GLOBAL_UNIT = 4'hF;
  localparam int CTL_EN      = 0;
  localparam int CTL_IE      = 1;
  localparam int EVS_EN      = 4;
  localparam logic [IDX_W-1:0] G_CTL = 4'd0;
  localparam logic [IDX_W-1:0] G_STS = 4'd1;
  localparam logic [IDX_W-1:0] G_CLR = 4'd2;
endpackage

// File: rtl/pcu_counter.sv
module pcu_counter #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    wrap   = inc & ~we & (&cnt);
    cnt_en = inc | we;
    cnt_d  = we ? wdata : cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  // R10: a preload wins over a concurrent step
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> cnt == $past(wdata));
  // R3: a step below all ones adds exactly one
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !we && !(&cnt)) |=> cnt == $past(cnt) + W'(1));
  // R6: stepping from all ones lands on zero
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !we && (&cnt)) |=> cnt == '0);
endmodule

// File: rtl/pcu_box.sv
module pcu_box
  import pcu_pkg::*;
#(
  parameter int CW   = 48,
  parameter int N_GP = 4,
  parameter int EV_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen,
  input  logic [EV_N-1:0]  ev,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [CW-1:0]    wdata,
  output logic [CW-1:0]    rdata,
  output logic             any_ovf_d,
  output logic             int_en
);
  localparam int SELW  = $clog2(EV_N);
  localparam int NCNT  = N_GP + 1;
  localparam int I_FIX = N_GP;
  localparam int I_EVS = N_GP + 1;
  localparam int I_CTL = 2 * N_GP + 1;
  localparam int I_STS = 2 * N_GP + 2;
  localparam int I_CLR = 2 * N_GP + 3;

  logic [SELW-1:0] sel_q [N_GP];
  logic [SELW-1:0] sel_d [N_GP];
  logic [N_GP-1:0] sen_q, sen_d;
  logic [1:0]      ctl_q, ctl_d;
  logic [NCNT-1:0] sts_q, sts_d;
  logic [NCNT-1:0] inc, cwe, wrap;
  logic [CW-1:0]   cnt [NCNT];

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    if (g < N_GP) begin : g_prog
      assign inc[g] = gen & ctl_q[CTL_EN] & sen_q[g] & ev[sel_q[g]];
    end else begin : g_fixed
      assign inc[g] = gen & ctl_q[CTL_EN];
    end
    assign cwe[g] = we && (idx == IDX_W'(g));
    pcu_counter #(.W(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc[g]), .we(cwe[g]),
      .wdata(wdata), .cnt(cnt[g]), .wrap(wrap[g])
    );
    // R7: an overflow flag persists unless its clear bit is written
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[g] && !(we && idx == IDX_W'(I_CLR) && wdata[g])) |=> sts_q[g]);
  end

  always_comb begin
    ctl_d = ctl_q;
    sen_d = sen_q;
    for (int i = 0; i < N_GP; i++) begin
      sel_d[i] = sel_q[i];
      if (we && idx == IDX_W'(I_EVS + i)) begin
        sel_d[i] = wdata[SELW-1:0];
        sen_d[i] = wdata[EVS_EN];
      end
    end
    if (we && idx == IDX_W'(I_CTL)) ctl_d = wdata[1:0];
    sts_d = sts_q;
    if (we && idx == IDX_W'(I_CLR)) sts_d = sts_q & ~wdata[NCNT-1:0];
    sts_d     = sts_d | wrap;
    any_ovf_d = |sts_d;
    int_en    = ctl_q[CTL_IE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      sen_q <= '0;
      sts_q <= '0;
      for (int i = 0; i < N_GP; i++) sel_q[i] <= '0;
    end else begin
      ctl_q <= ctl_d;
      sen_q <= sen_d;
      sts_q <= sts_d;
      for (int i = 0; i < N_GP; i++) sel_q[i] <= sel_d[i];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCNT; i++)
      if (idx == IDX_W'(i)) rdata = cnt[i];
    for (int i = 0; i < N_GP; i++)
      if (idx == IDX_W'(I_EVS + i)) begin
        rdata[SELW-1:0] = sel_q[i];
        rdata[EVS_EN]   = sen_q[i];
      end
    if (idx == IDX_W'(I_CTL)) rdata[1:0] = ctl_q;
    if (idx == IDX_W'(I_STS)) rdata[NCNT-1:0] = sts_q;
  end

  // R4: with the master enable low only a preload moves the fixed counter
  a_r4_gen_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen && !cwe[I_FIX]) |=> $stable(cnt[I_FIX]));
endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int N_BOX = 2,
  parameter int CW    = 48,
  parameter int N_GP  = 4,
  parameter int EV_N  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [7:0]            reg_addr,
  input  logic [CW-1:0]         reg_wdata,
  output logic [CW-1:0]         reg_rdata,
  input  logic [N_BOX*EV_N-1:0] ev_in,
  output logic                  irq
);
  logic [1:0]       rst_s;
  logic             rst_i;
  logic [UNIT_W-1:0] unit;
  logic [IDX_W-1:0] idx;
  logic [1:0]       gctl_q, gctl_d;
  logic [N_BOX-1:0] gsts_q, gsts_d, gclr;
  logic [N_BOX-1:0] box_any, box_ie;
  logic [CW-1:0]    box_rd [N_BOX];
  logic             g_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_s <= '0;
    else        rst_s <= {rst_s[0], 1'b1};
  end
  assign rst_i = rst_s[1];

  assign unit  = reg_addr[7:4];
  assign idx   = reg_addr[3:0];
  assign g_sel = (unit == GLOBAL_UNIT);

  for (genvar b = 0; b < N_BOX; b++) begin : g_box
    pcu_box #(.CW(CW), .N_GP(N_GP), .EV_N(EV_N)) u_box (
      .clk(clk), .rst_n(rst_i), .gen(gctl_q[CTL_EN]),
      .ev(ev_in[b*EV_N +: EV_N]),
      .we(reg_we && unit == UNIT_W'(b)), .idx(idx), .wdata(reg_wdata),
      .rdata(box_rd[b]), .any_ovf_d(box_any[b]), .int_en(box_ie[b])
    );
    // R8: a box reporting overflow is flagged at the global level
    a_r8_global_follows: assert property (@(posedge clk) disable iff (!rst_i)
      box_any[b] |=> gsts_q[b]);
  end

  always_comb begin
    gctl_d = gctl_q;
    if (reg_we && g_sel && idx == G_CTL) gctl_d = reg_wdata[1:0];
    gclr = '0;
    if (reg_we && g_sel && idx == G_CLR) gclr = reg_wdata[N_BOX-1:0];
    gsts_d = box_any | (gsts_q & ~gclr);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      gctl_q <= '0;
      gsts_q <= '0;
    end else begin
      gctl_q <= gctl_d;
      gsts_q <= gsts_d;
    end
  end

  assign irq = gctl_q[CTL_IE] & (|(gsts_q & box_ie));

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < N_BOX; b++)
      if (unit == UNIT_W'(b)) reg_rdata = box_rd[b];
    if (g_sel && idx == G_CTL) reg_rdata[1:0] = gctl_q;
    if (g_sel && idx == G_STS) reg_rdata[N_BOX-1:0] = gsts_q;
  end

  // R9: no interrupt while the global interrupt enable is clear
  a_r9_global_mask: assert property (@(posedge clk) disable iff (!rst_i)
    !gctl_q[CTL_IE] |-> !irq);
endmodule

// File: tb/sim_pcu_top.sv
module sim_pcu_top;
  localparam logic [47:0] MAX = 48'hFFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [47:0] reg_wdata = '0;
  logic [47:0] reg_rdata;
  logic [15:0] ev_in = '0;
  logic        irq;

  pcu_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_in(ev_in), .irq(irq)
  );

  always #5 clk = ~clk;

  int    total = 0;
  int    bad = 0;
  bit    chk_on = 0;
  bit    done = 0;
  int    ev_mode = 0;
  int    sweep = 0;
  string cur_req = "R1";

  logic [47:0] m_cnt [2][5];
  logic [2:0]  m_sel [2][4];
  logic        m_sen [2][4];
  logic [1:0]  m_ctl [2];
  logic [4:0]  m_sts [2];
  logic [1:0]  m_gctl;
  logic [1:0]  m_gsts;
  logic        m_irq;

  initial begin
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 5; i++) m_cnt[b][i] = '0;
      for (int i = 0; i < 4; i++) begin m_sel[b][i] = '0; m_sen[b][i] = 1'b0; end
      m_ctl[b] = '0; m_sts[b] = '0;
    end
    m_gctl = '0; m_gsts = '0; m_irq = 1'b0;
  end

  function automatic logic [47:0] model_read(logic [7:0] a);
    int u = int'(a[7:4]);
    int r = int'(a[3:0]);
    logic [47:0] v = '0;
    if (u < 2) begin
      if (r < 5) v = m_cnt[u][r];
      else if (r < 9) v = {43'd0, m_sen[u][r-5], 1'b0, m_sel[u][r-5]};
      else if (r == 9) v = {46'd0, m_ctl[u]};
      else if (r == 10) v = {43'd0, m_sts[u]};
    end else if (u == 15) begin
      if (r == 0) v = {46'd0, m_gctl};
      else if (r == 1) v = {46'd0, m_gsts};
    end
    return v;
  endfunction

  task automatic chk(bit ok, string what, logic [47:0] got, logic [47:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic        w;
    logic [7:0]  a;
    logic [47:0] d;
    logic [15:0] evs;
    logic [4:0]  set;
    logic        inc;
    w = reg_we; a = reg_addr; d = reg_wdata; evs = ev_in;
    for (int b = 0; b < 2; b++) begin
      set = '0;
      for (int i = 0; i < 5; i++) begin
        if (i < 4) inc = m_gctl[0] && m_ctl[b][0] && m_sen[b][i] && evs[b*8 + int'(m_sel[b][i])];
        else       inc = m_gctl[0] && m_ctl[b][0];
        if (w && a == {4'(b), 4'(i)}) m_cnt[b][i] = d;
        else if (inc) begin
          if (m_cnt[b][i] == MAX) begin m_cnt[b][i] = '0; set[i] = 1'b1; end
          else m_cnt[b][i] = m_cnt[b][i] + 48'd1;
        end
      end
      if (w && a == {4'(b), 4'd11}) m_sts[b] = m_sts[b] & ~d[4:0];
      m_sts[b] = m_sts[b] | set;
      for (int i = 0; i < 4; i++)
        if (w && a == {4'(b), 4'(5 + i)}) begin m_sel[b][i] = d[2:0]; m_sen[b][i] = d[4]; end
      if (w && a == {4'(b), 4'd9}) m_ctl[b] = d[1:0];
    end
    for (int b = 0; b < 2; b++) begin
      if (w && a == 8'hF2 && d[b]) m_gsts[b] = 1'b0;
      if (m_sts[b] != 0) m_gsts[b] = 1'b1;
    end
    if (w && a == 8'hF0) m_gctl = d[1:0];
    m_irq = m_gctl[1] && ((m_gsts[0] && m_ctl[0][1]) || (m_gsts[1] && m_ctl[1][1]));
    #2;
    if (chk_on) begin
      chk(reg_rdata == model_read(reg_addr), $sformatf("rdata@%h", reg_addr), reg_rdata, model_read(reg_addr));
      chk(irq == m_irq, "irq", {47'd0, irq}, {47'd0, m_irq});
    end
  end

  function automatic logic [7:0] sweep_addr(int s);
    int k = s % 28;
    if (k < 12) return {4'd0, 4'(k)};
    if (k < 24) return {4'd1, 4'(k - 12)};
    if (k < 27) return {4'hF, 4'(k - 24)};
    return 8'h2C;
  endfunction

  task automatic drive_ev();
    case (ev_mode)
      0: ev_in = '0;
      1: ev_in = '1;
      default: ev_in = 16'($urandom);
    endcase
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      drive_ev();
      reg_we = 1'b0;
      reg_addr = sweep_addr(sweep);
      sweep++;
    end
  endtask

  task automatic wr(logic [7:0] a, logic [47:0] d);
    @(negedge clk);
    drive_ev();
    reg_we = 1'b1;
    reg_addr = a;
    reg_wdata = d;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_on = 1;
    cur_req = "R1"; idle(28);
    cur_req = "R2";
    for (int i = 0; i < 4; i++) wr(8'h05 + 8'(i), 48'h10 + 48'(i));
    for (int i = 0; i < 4; i++) wr(8'h15 + 8'(i), 48'h14 + 48'(i));
    wr(8'h09, 48'h3); wr(8'h19, 48'h3);
    wr(8'h30, 48'hFF); wr(8'h2C, 48'h1234);
    idle(28);
    cur_req = "R7"; wr(8'h0A, 48'h1F); wr(8'h1A, 48'h1F); idle(4);
    cur_req = "R4"; ev_mode = 2; idle(40);
    wr(8'hF0, 48'h1); wr(8'h19, 48'h2); idle(40);
    wr(8'h07, 48'h02); idle(30);
    cur_req = "R3"; wr(8'h19, 48'h3); wr(8'h07, 48'h12); idle(100);
    cur_req = "R5"; ev_mode = 0; idle(20);
    cur_req = "R6"; ev_mode = 1;
    wr(8'h01, MAX - 48'd5); wr(8'h14, MAX - 48'd3); idle(12);
    cur_req = "R9";
    wr(8'hF0, 48'h3); idle(3);
    wr(8'h19, 48'h1); wr(8'h09, 48'h1); idle(3);
    wr(8'h09, 48'h3); idle(3);
    cur_req = "R7";
    wr(8'h0B, 48'h0); idle(3);
    wr(8'h0B, 48'h2); idle(3);
    cur_req = "R8";
    wr(8'hF2, 48'h3); idle(3);
    wr(8'h1B, 48'h1F); wr(8'h0B, 48'h1F); idle(2);
    wr(8'hF2, 48'h3); idle(3);
    cur_req = "R7";
    wr(8'h02, MAX - 48'd2); idle(1); idle(1); wr(8'h0B, 48'h04); idle(5);
    cur_req = "R10";
    wr(8'h00, 48'h123); idle(2);
    wr(8'h03, MAX); wr(8'h03, 48'h5); idle(4);
    wr(8'h10, MAX); idle(3);
    cur_req = "R3"; ev_mode = 2; idle(200);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog %s got=hung exp=finish", cur_req);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule